// File: doc/BRIEF.md
# Bit Set/Reset Output Port

This block holds an eight-bit output latch for a group of general-purpose pins. Software never writes the latch as a whole. It uses two write addresses instead. One address turns on the bits marked in the data word, and the other turns them off. Any data bit that is zero leaves its latch bit as it was. This lets independent pieces of software each control their own pins without a read-modify-write sequence.

The pins are active-low with respect to the latch. A latch bit of one drives its pin low, and a latch bit of zero lets it go high. A third write address loads a per-pin routing mask. When a pin's mask bit is one, the pin follows an auxiliary signal supplied by a neighbouring channel block, and the latch bit no longer controls it. The latch bit can still be written while it is hidden. It shows again once the pin returns to general-purpose use.

Top module: `bsr_out_port`

## Requirements
- R1: A synchronous active-high reset clears both the latch and the routing mask, so every pin reads high after the first clock edge with reset asserted.
- R2: A write (wr_en=1) to address 2'b00 sets each latch bit whose data bit is one and leaves the other latch bits unchanged, effective at the next rising clock edge.
- R3: A write to address 2'b01 clears each latch bit whose data bit is one and leaves the other latch bits unchanged, effective at the next rising clock edge.
- R4: A pin whose routing mask bit is zero drives the complement of its latch bit.
- R5: A write to address 2'b10 loads the whole routing mask from the data word at the next rising edge. A pin whose mask bit is one follows its aux_in bit combinationally.
- R6: Writes to the latch still take effect for pins in auxiliary mode but do not alter those pins. The stored value appears, inverted, as soon as the mask bit returns to zero.
- R7: A write to address 2'b11, or any cycle with wr_en=0, changes neither the latch nor the routing mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write target: 00 set, 01 clear, 10 routing mask, 11 unused |
| wr_data | input | 8 | Write data word |
| aux_in | input | 8 | Auxiliary function signals, one per pin |
| pin_out | output | 8 | Port pins |

## Verification
A write is captured at the rising edge after the cycle in which it is presented. The pins reflect it right after that edge, because the path from the registers to the pins has no further stage. A change on aux_in reaches a routed pin in the same cycle with no edge in between. The bench drives every input on the falling edge. Its reference model applies writes at the rising edge, and it compares the pins two nanoseconds after each rising edge, so both kinds of result are due at every sample point. Fixed-value checks at chosen points also confirm the inversion, the hidden writes and the ignored address against literals worked out by hand.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    parameter int PORT_W = 8;
    parameter int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_SET  = 2'd0,
        ADR_CLR  = 2'd1,
        ADR_CFG  = 2'd2,
        ADR_NONE = 2'd3
    } bsr_addr_e;

    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic cfg_en;
    } bsr_cmd_t;

    function automatic bsr_cmd_t bsr_decode(input logic en, input logic [ADDR_W-1:0] adr);
        bsr_cmd_t c;
        c = '0;
        if (en) begin
            case (bsr_addr_e'(adr))
                ADR_SET: c.set_en = 1'b1;
                ADR_CLR: c.clr_en = 1'b1;
                ADR_CFG: c.cfg_en = 1'b1;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    function automatic logic bsr_next_bit(input logic cur, input logic d, input bsr_cmd_t c);
        logic n;
        n = cur;
        if (c.set_en && d)      n = 1'b1;
        else if (c.clr_en && d) n = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/bsr_wr_decode.sv
module bsr_wr_decode
    import bsr_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output bsr_cmd_t          cmd
);
    always_comb begin
        cmd = bsr_decode(wr_en, wr_addr);
    end
endmodule

// File: rtl/bsr_bit_reg.sv
module bsr_bit_reg
    import bsr_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bsr_cmd_t     cmd,
    input  logic [W-1:0] data,
    output logic [W-1:0] port_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) port_q[i] <= 1'b0;
            else     port_q[i] <= bsr_next_bit(port_q[i], data[i], cmd);
        end
    end
endmodule

// File: rtl/bsr_sel_reg.sv
module bsr_sel_reg
    import bsr_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bsr_cmd_t     cmd,
    input  logic [W-1:0] data,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)             cfg_q <= '0;
        else if (cmd.cfg_en) cfg_q <= data;
    end
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux #(
    parameter int W = bsr_pkg::PORT_W
) (
    input  logic [W-1:0] port_q,
    input  logic [W-1:0] cfg_q,
    input  logic [W-1:0] aux_in,
    output logic [W-1:0] pin_out
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (cfg_q[i]) pin_out[i] = aux_in[i];
            else          pin_out[i] = ~port_q[i];
        end
    end
endmodule

// File: rtl/bsr_out_port.sv
module bsr_out_port
    import bsr_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      aux_in,
    output logic [W-1:0]      pin_out
);
    bsr_cmd_t     cmd;
    logic [W-1:0] port_q;
    logic [W-1:0] cfg_q;

    bsr_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd)
    );

    bsr_bit_reg #(.W(W)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .data   (wr_data),
        .port_q (port_q)
    );

    bsr_sel_reg #(.W(W)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .data  (wr_data),
        .cfg_q (cfg_q)
    );

    bsr_pin_mux #(.W(W)) u_mux (
        .port_q  (port_q),
        .cfg_q   (cfg_q),
        .aux_in  (aux_in),
        .pin_out (pin_out)
    );
endmodule

// File: rtl/bsr_out_port_chk.sv
module bsr_out_port_chk #(
    parameter int W = bsr_pkg::PORT_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [bsr_pkg::ADDR_W-1:0] wr_addr,
    input logic [W-1:0]              wr_data,
    input logic [W-1:0]              aux_in,
    input logic [W-1:0]              pin_out,
    input logic [W-1:0]              port_q,
    input logic [W-1:0]              cfg_q
);
    localparam logic [1:0] A_SET = 2'd0;
    localparam logic [1:0] A_CLR = 2'd1;
    localparam logic [1:0] A_CFG = 2'd2;
    localparam logic [1:0] A_OFF = 2'd3;

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (pin_out | cfg_q) == {W{1'b1}} || cfg_q != '0);

    p_reset_regs_r1: assert property (@(posedge clk)
        $past(rst) |-> port_q == '0 && cfg_q == '0);

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == A_SET |=> port_q == ($past(port_q) | $past(wr_data)));

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == A_CLR |=> port_q == ($past(port_q) & ~$past(wr_data)));

    p_invert_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_q == '0 |-> pin_out == ~port_q);

    p_cfg_load_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == A_CFG |=> cfg_q == $past(wr_data));

    p_aux_route_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_q == {W{1'b1}} |-> pin_out == aux_in);

    p_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_q == {W{1'b1}} && $stable(cfg_q) && $stable(aux_in) |-> $stable(pin_out));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en || wr_addr == A_OFF |=> $stable(port_q) && $stable(cfg_q));
endmodule

bind bsr_out_port bsr_out_port_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .aux_in  (aux_in),
    .pin_out (pin_out),
    .port_q  (port_q),
    .cfg_q   (cfg_q)
);

// File: tb/sim_bsr_out_port.sv
`timescale 1ns/1ps
module sim_bsr_out_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] aux_in = 8'd0;
    logic [7:0] pin_out;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    logic [7:0] m_latch = 8'd0;
    logic [7:0] m_route = 8'd0;

    always #5 clk = ~clk;

    bsr_out_port u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .aux_in  (aux_in),
        .pin_out (pin_out)
    );

    function automatic logic [7:0] model_pins();
        logic [7:0] p;
        for (int i = 0; i < 8; i++)
            p[i] = m_route[i] ? aux_in[i] : !m_latch[i];
        return p;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pin_out=%02h expected=%02h at %0t", req, got, exp, $time);
        end
    endtask

    // reference model: applies writes at the rising edge, compares 2 ns later
    always @(posedge clk) begin
        if (rst) begin
            m_latch = 8'd0;
            m_route = 8'd0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: m_latch = m_latch | wr_data;
                2'd1: m_latch = m_latch & ~wr_data;
                2'd2: m_route = wr_data;
                default: ;
            endcase
        end
        #2;
        check(cur_req, pin_out, model_pins());
    end

    task automatic put(input string req, input logic en, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cur_req = req;
        wr_en = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fixed(input string req, input logic [7:0] exp);
        #1;
        check(req, pin_out, exp);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        fixed("R1", 8'hFF);                 // R1: pins high after reset
        rst = 1'b0;
        put("R2", 1'b1, 2'd0, 8'h0F); fixed("R2", 8'hF0);
        put("R2", 1'b1, 2'd0, 8'h30); fixed("R2", 8'hC0);
        put("R3", 1'b1, 2'd1, 8'h05); fixed("R3", 8'hC5);   // latch 3A
        put("R3", 1'b1, 2'd1, 8'h00); fixed("R3", 8'hC5);
        fixed("R4", ~8'h3A);                // R4: inversion of latch 3A
        put("R7", 1'b1, 2'd3, 8'hFF); fixed("R7", 8'hC5);
        put("R7", 1'b0, 2'd0, 8'hFF); fixed("R7", 8'hC5);
        put("R7", 1'b0, 2'd1, 8'hFF); fixed("R7", 8'hC5);
        aux_in = 8'h60;
        put("R5", 1'b1, 2'd2, 8'hF0); fixed("R5", 8'h65);
        @(negedge clk); cur_req = "R5"; aux_in = 8'h90; fixed("R5", 8'h95);
        put("R6", 1'b1, 2'd0, 8'hC0); fixed("R6", 8'h95);  // latch FA hidden upper
        put("R6", 1'b1, 2'd1, 8'h01); fixed("R6", 8'h95);  // latch FA unchanged
        put("R6", 1'b1, 2'd2, 8'h00); fixed("R6", 8'h05);  // latch FA revealed
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            cur_req = "R4";
            wr_en = 1'($urandom);
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
            aux_in = 8'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        put("R2", 1'b1, 2'd2, 8'h00);
        put("R2", 1'b1, 2'd0, 8'hFF); fixed("R2", 8'h00);
        @(negedge clk); cur_req = "R1"; rst = 1'b1;
        @(negedge clk); fixed("R1", 8'hFF);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule